// File: doc/BRIEF.md
# Object Record Buffer Drain

This block empties a small buffer of detected-object records into a byte-wide FIFO bridge toward a host link. A separate writer fills a synchronous RAM with records while a frame is valid. When the frame ends, the writer raises a ready signal and offers the number of records it stored. The drain then holds a lock so the writer leaves the RAM alone. It reads the stored records one by one, starting at address zero. Each record is cut into bytes, and each byte goes out under a write strobe that the bridge can stall with its full flag.

A record is 48 bits wide. It holds an 8-bit colour label and then four 10-bit corner coordinates. Once the last byte of the last record has been accepted, the lock drops and the block goes back to idle. A count of zero sends nothing, but the lock still pulses, so the writer sees that its buffer has been handed back.

Top module: `record_drain`

## Requirements
- R1: While reset is high and in the first cycle after it, the lock and the byte strobe are both low.
- R2: An upload starts only after the ready input has been seen low and then high. Ready held high after reset, or after an upload, starts nothing. The lock rises in the cycle after ready is sampled high while armed.
- R3: The lock is high whenever the byte strobe is high. After the final byte is accepted, the lock is low in the next cycle and stays low for at least one cycle.
- R4: The RAM addresses read during an upload run 0, 1, ..., count-1 in order. The address only steps by one or returns to zero. Exactly count records are sent, and the count may be as large as 127.
- R5: Each record goes out as 6 bytes, most significant first. Byte 0 is the colour label (bits 47:40), and the last byte is bits 7:0 (the low part of the y2 coordinate). Records are packed as {label[7:0], x1, y1, x2, y2}, each coordinate 10 bits.
- R6: A byte transfers only on a clock edge where the strobe is high and the full flag is low. While full is high, the strobe stays high and the byte and read address stay unchanged.
- R7: A count of zero produces no strobe, and the lock is high for exactly one cycle.
- R8: The RAM has one cycle of read latency. The address is held one cycle before the data is captured, so every byte matches the record stored at the address that was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy_i | input | 1 | Buffer-ready signal from the writer |
| count_i | input | 7 | Number of stored records, taken at upload start |
| rd_data_i | input | 48 | RAM read data, valid one cycle after the address |
| full_i | input | 1 | Bridge full flag; a byte moves only when this is low |
| lock_o | output | 1 | Lock toward the writer, high during an upload |
| rd_addr_o | output | 7 | RAM read address |
| byte_o | output | 8 | Byte offered to the bridge |
| wr_o | output | 1 | Byte write strobe |

## Verification
Once ready is sampled high while armed, the lock rises one edge later. The first strobe follows three edges after that, and each further record adds two idle cycles after its sixth accepted byte. The lock is low one edge after the final acceptance. The bench drives inputs one time unit after a rising edge and samples all outputs on the falling edge. This way a strobe and a full flag seen together are the values the next rising edge acts on. A scoreboard queue receives the expected bytes before ready rises, and the monitor pops one byte for every accepted strobe. Stalls are checked at the next falling edge against the byte and address seen during the stall.

// File: rtl/record_drain_pkg.sv
package record_drain_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOCK,
      ST_READ_ADDR,
      ST_LOAD_WORD,
      ST_SEND_BYTES,
      ST_DONE
   } drain_state_t;
endpackage

// File: rtl/record_drain_arm.sv
module record_drain_arm (
   input  logic clk,
   input  logic rst,
   input  logic rdy_i,
   input  logic take_i,
   output logic start_o
);
   logic armed_q;

   always_ff @(posedge clk) begin
      if (rst)
         armed_q <= 1'b0;
      else if (!rdy_i)
         armed_q <= 1'b1;
      else if (take_i)
         armed_q <= 1'b0;
   end

   assign start_o = armed_q & rdy_i;
endmodule

// File: rtl/record_drain_ser.sv
module record_drain_ser #(
   parameter int REC_W     = 48,
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic [REC_W-1:0]  data_i,
   input  logic              adv_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              last_o
);
   localparam int NBYTES = REC_W / BYTE_W;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   logic [REC_W-1:0] sreg_q;
   logic [IDX_W-1:0] idx_q;

   assign last_o = (idx_q == IDX_W'(NBYTES - 1));

   always_ff @(posedge clk) begin
      if (rst)
         idx_q <= '0;
      else if (load_i)
         idx_q <= '0;
      else if (adv_i)
         idx_q <= last_o ? '0 : idx_q + 1'b1;
   end

   generate
      if (MSB_FIRST) begin : g_msb
         assign byte_o = sreg_q[REC_W-1 -: BYTE_W];
         always_ff @(posedge clk) begin
            if (rst)         sreg_q <= '0;
            else if (load_i) sreg_q <= data_i;
            else if (adv_i)  sreg_q <= sreg_q << BYTE_W;
         end
      end else begin : g_lsb
         assign byte_o = sreg_q[BYTE_W-1:0];
         always_ff @(posedge clk) begin
            if (rst)         sreg_q <= '0;
            else if (load_i) sreg_q <= data_i;
            else if (adv_i)  sreg_q <= sreg_q >> BYTE_W;
         end
      end
   endgenerate
endmodule

// File: rtl/record_drain.sv
module record_drain
   import record_drain_pkg::*;
#(
   parameter int LABEL_W   = 8,
   parameter int COORD_W   = 10,
   parameter int NUM_COORD = 4,
   parameter int BYTE_W    = 8,
   parameter int ADDR_W    = 7,
   parameter bit MSB_FIRST = 1'b1,
   localparam int REC_W    = LABEL_W + NUM_COORD * COORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rdy_i,
   input  logic [ADDR_W-1:0] count_i,
   input  logic [REC_W-1:0]  rd_data_i,
   input  logic              full_i,
   output logic              lock_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              wr_o
);
   generate
      if (REC_W % BYTE_W != 0) begin : g_bad_pack
         $error("record width must be a whole number of bytes");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be at least 1");
      end
   endgenerate

   drain_state_t      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] cnt_q;
   logic              start;
   logic              go;
   logic              accept;
   logic              last_byte;
   logic              last_rec;

   assign go       = start && (state_q == ST_IDLE);
   assign wr_o     = (state_q == ST_SEND_BYTES);
   assign accept   = wr_o && !full_i;
   assign last_rec = ((addr_q + ADDR_W'(1)) == cnt_q);
   assign lock_o   = (state_q == ST_LOCK) || (state_q == ST_READ_ADDR) ||
                     (state_q == ST_LOAD_WORD) || (state_q == ST_SEND_BYTES);
   assign rd_addr_o = addr_q;

   record_drain_arm u_arm (
      .clk     (clk),
      .rst     (rst),
      .rdy_i   (rdy_i),
      .take_i  (go),
      .start_o (start)
   );

   record_drain_ser #(
      .REC_W     (REC_W),
      .BYTE_W    (BYTE_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_ser (
      .clk    (clk),
      .rst    (rst),
      .load_i (state_q == ST_LOAD_WORD),
      .data_i (rd_data_i),
      .adv_i  (accept),
      .byte_o (byte_o),
      .last_o (last_byte)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (go) begin
                  cnt_q   <= count_i;
                  state_q <= ST_LOCK;
               end
            end
            ST_LOCK: begin
               addr_q  <= '0;
               state_q <= (cnt_q == '0) ? ST_DONE : ST_READ_ADDR;
            end
            ST_READ_ADDR: state_q <= ST_LOAD_WORD;
            ST_LOAD_WORD: state_q <= ST_SEND_BYTES;
            ST_SEND_BYTES: begin
               if (accept && last_byte) begin
                  if (last_rec) begin
                     state_q <= ST_DONE;
                  end else begin
                     addr_q  <= addr_q + 1'b1;
                     state_q <= ST_READ_ADDR;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/record_drain_chk.sv
module record_drain_chk #(
   parameter int ADDR_W = 7,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              rdy_i,
   input logic              full_i,
   input logic              lock_o,
   input logic [ADDR_W-1:0] rd_addr_o,
   input logic [BYTE_W-1:0] byte_o,
   input logic              wr_o
);
   AST_HOLD_ON_FULL: assert property (@(posedge clk) disable iff (rst)
      (wr_o && full_i) |=> (wr_o && $stable(byte_o) && $stable(rd_addr_o))); // R6

   AST_WR_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
      wr_o |-> lock_o); // R3

   AST_LOCK_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(lock_o) |=> !lock_o); // R3

   AST_START_ON_READY: assert property (@(posedge clk) disable iff (rst)
      $rose(lock_o) |-> $past(rdy_i)); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
      (lock_o && !$stable(rd_addr_o)) |->
         ((rd_addr_o == ADDR_W'($past(rd_addr_o) + 1'b1)) || (rd_addr_o == '0))); // R4
endmodule

bind record_drain record_drain_chk #(
   .ADDR_W (ADDR_W),
   .BYTE_W (BYTE_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .rdy_i     (rdy_i),
   .full_i    (full_i),
   .lock_o    (lock_o),
   .rd_addr_o (rd_addr_o),
   .byte_o    (byte_o),
   .wr_o      (wr_o)
);

// File: tb/record_drain_test.sv
module record_drain_test;
   logic        clk = 1'b0;
   logic        rst;
   logic        rdy;
   logic        full;
   logic [6:0]  cnt;
   logic [47:0] rdata;
   logic        lock;
   logic [6:0]  addr;
   logic [7:0]  byte_v;
   logic        wr;
   logic [47:0] mem [128];

   always #2.5 clk = ~clk;

   always_ff @(posedge clk) rdata <= mem[addr];

   record_drain uut (
      .clk       (clk),
      .rst       (rst),
      .rdy_i     (rdy),
      .count_i   (cnt),
      .rd_data_i (rdata),
      .full_i    (full),
      .lock_o    (lock),
      .rd_addr_o (addr),
      .byte_o    (byte_v),
      .wr_o      (wr)
   );

   int         total = 0;
   int         bad = 0;
   logic [7:0] expq [$];
   int         acc_bytes = 0;
   int         lock_len = 0;
   int         last_lock_len = 0;
   int         lock_rises = 0;
   logic       prev_lock = 1'b0;
   logic       pend_stall = 1'b0;
   logic [7:0] stall_byte;
   logic [6:0] stall_addr;
   logic       chk_gap = 1'b0;
   int         full_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // full flag driver
   initial begin
      full = 1'b0;
      forever begin
         @(posedge clk); #1;
         case (full_mode)
            0: full = 1'b0;
            1: full = ~full;
            default: begin
               lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
               full = lfsr[0] & lfsr[3];
            end
         endcase
      end
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         if (pend_stall) begin
            check(wr && byte_v == stall_byte && addr == stall_addr, "R6",
                  "stalled byte/address changed", int'(byte_v), int'(stall_byte));
            pend_stall = 1'b0;
         end
         if (chk_gap) begin
            check(!lock, "R3", "lock after final byte", int'(lock), 0);
            chk_gap = 1'b0;
         end
         if (wr) check(lock, "R3", "strobe without lock", int'(lock), 1);
         if (wr && !full) begin
            acc_bytes++;
            if (expq.size() == 0) begin
               check(1'b0, "R4", "unexpected byte", int'(byte_v), -1);
            end else begin
               automatic logic [7:0] e = expq.pop_front();
               check(byte_v == e, "R5 R8", "byte value", int'(byte_v), int'(e));
               if (expq.size() == 0) chk_gap = 1'b1;
            end
         end else if (wr && full) begin
            pend_stall = 1'b1;
            stall_byte = byte_v;
            stall_addr = addr;
         end
         if (lock && !prev_lock) lock_rises++;
         if (lock) lock_len++;
         else if (lock_len != 0) begin
            last_lock_len = lock_len;
            lock_len = 0;
         end
         prev_lock = lock;
      end
   end

   task automatic run_upload(input int n, input int seed, input int mode);
      full_mode = mode;
      @(posedge clk); #1;
      rdy = 1'b0;
      for (int i = 0; i < n; i++) begin
         automatic logic [7:0] lab = 8'((i * 7 + seed) & 8'hFF);
         automatic logic [9:0] x1 = 10'((i * 13 + seed * 3) & 10'h3FF);
         automatic logic [9:0] y1 = 10'((i * 13 + seed * 3 + 1) & 10'h3FF);
         automatic logic [9:0] x2 = 10'((i * 29 + seed + 2) & 10'h3FF);
         automatic logic [9:0] y2 = 10'((i * 31 + seed * 5 + 3) & 10'h3FF);
         mem[i] = {lab, x1, y1, x2, y2};
         for (int k = 0; k < 6; k++) expq.push_back(mem[i][47 - 8 * k -: 8]);
      end
      cnt = 7'(n);
      acc_bytes = 0;
      repeat (2) @(posedge clk);
      #1 rdy = 1'b1;
      while (!lock) @(posedge clk);
      while (lock) @(posedge clk);
      repeat (4) @(posedge clk);
      check(expq.size() == 0, "R4", "bytes left unsent", expq.size(), 0);
      check(acc_bytes == 6 * n, "R6", "accepted byte total", acc_bytes, 6 * n);
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int rises_before;
      for (int i = 0; i < 128; i++) mem[i] = '0;
      rst = 1'b1;
      rdy = 1'b1;
      cnt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!lock && !wr, "R1", "outputs in reset", int'({lock, wr}), 0);
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check(!lock && !wr, "R1", "outputs after reset", int'({lock, wr}), 0);
      repeat (10) @(posedge clk);
      @(negedge clk);
      check(lock_rises == 0, "R2", "start without ready low", lock_rises, 0);

      run_upload(3, 1, 0);
      rises_before = lock_rises;
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(lock_rises == rises_before, "R2", "restart while ready held",
            lock_rises, rises_before);

      run_upload(5, 9, 1);
      run_upload(0, 4, 0);
      check(acc_bytes == 0, "R7", "bytes for zero count", acc_bytes, 0);
      check(last_lock_len == 1, "R7", "lock pulse width", last_lock_len, 1);
      run_upload(1, 17, 2);
      run_upload(127, 23, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule